// File: doc/BRIEF.md
# Operand Effective Address Generator

This block turns one operand specifier into the value that the operand access needs: a memory address, an immediate constant or a register operand. Decode hands it a mode code, a register index, a displacement or constant field and the current program counter. The unit reads the register file through a combinational read port. For the two auto-modify modes it also issues a register write. For memory-indirect addressing it fetches a pointer word through a request/ready read handshake.

A request is taken on `start` while `busy` is low. Every mode except memory-indirect finishes in the next cycle: `done` pulses, `result` carries the address or operand, and `kind` says which of the three it is. Memory-indirect raises `mem_req` in the next cycle and holds it until `mem_ready`. The returned word appears on `result` with `done` one cycle after the ready cycle. Address arithmetic wraps modulo 2^AW and raises no overflow flag.

Mode codes on `mode`:

| Code | Mode |
|------|------|
| 0 | immediate |
| 1 | register |
| 2 | absolute |
| 3 | register-indirect |
| 4 | memory-indirect |
| 5 | indexed |
| 6 | PC-relative |
| 7 | autoincrement |
| 8 | autodecrement |

Codes 9 to 15 are reserved.

The `kind` codes are 0 for a memory address, 1 for an immediate and 2 for a register operand.

Top module: `ea_unit`

## Requirements
- R1: After reset `done`, `mem_req`, `rf_we` and `busy` are low.
- R2: Mode 0 (immediate) completes one cycle after `start`: `done`=1, `result`=`disp`, `kind`=1, and `rf_we`=0.
- R3: Mode 1 (register) returns the contents of the register at `reg_idx` on `result` with `kind`=2 one cycle after `start`.
- R4: Mode 2 (absolute) returns `disp` as the address with `kind`=0 one cycle after `start`.
- R5: Mode 3 (register-indirect) returns the contents of register `reg_idx` as the address with `kind`=0.
- R6: Mode 5 (indexed) returns `disp` plus the contents of register `reg_idx`, modulo 2^AW, with `kind`=0.
- R7: Mode 6 (PC-relative) returns `disp` plus `pc`, modulo 2^AW, with `kind`=0.
- R8: Mode 7 (autoincrement) returns the old register contents as the address. In the same cycle as `done` it writes that value plus STEP (default 4, wrapping) back to `reg_idx`.
- R9: Mode 8 (autodecrement) returns the register contents minus STEP as the address. In the same cycle as `done` it writes the same value back to `reg_idx`.
- R10: Mode 4 (memory-indirect) raises `mem_req` with `mem_addr`=`disp` one cycle after `start` and holds both until `mem_ready`. It then gives `done`=1, `result`=`mem_rdata` and `kind`=0 one cycle after the ready cycle.
- R11: While `busy` is high, `start` is ignored: no extra `done`, no register write and no change to the pending request.
- R12: Reserved mode codes 9 to 15 behave as absolute: `result`=`disp`, `kind`=0, no register write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Accept a specifier this cycle |
| mode | input | 4 | Addressing mode code |
| reg_idx | input | RW | Register index Ri |
| disp | input | AW | Displacement, address field or immediate constant |
| pc | input | AW | Program counter value |
| rf_raddr | output | RW | Register file read index |
| rf_rdata | input | AW | Register file read data (combinational) |
| rf_we | output | 1 | Register writeback enable |
| rf_waddr | output | RW | Register writeback index |
| rf_wdata | output | AW | Register writeback value |
| mem_req | output | 1 | Pointer read request |
| mem_addr | output | AW | Pointer read address |
| mem_ready | input | 1 | Pointer read data valid |
| mem_rdata | input | AW | Pointer read data |
| busy | output | 1 | Memory-indirect fetch in progress |
| done | output | 1 | Result valid pulse |
| result | output | AW | Effective address or operand value |
| kind | output | 2 | 0 address, 1 immediate, 2 register operand |

## Verification
A wrong mode decode or adder input shows on `result` or `kind` in the very cycle `done` pulses, so every single-cycle mode is compared at that point. A wrong auto-modify step or write timing shows in two places: on `rf_wdata` alongside `done`, and in the address the next access to the same register returns. A controller stuck in, or leaving early from, the fetch state shows within one cycle as `mem_req` dropping before `mem_ready`, `done` arriving early, or a second `done` from a start that should have been ignored.

// File: rtl/ea_pkg.sv
package ea_pkg;

  typedef enum logic [3:0] {
    AM_IMM  = 4'd0,
    AM_REG  = 4'd1,
    AM_ABS  = 4'd2,
    AM_INDR = 4'd3,
    AM_INDM = 4'd4,
    AM_IDX  = 4'd5,
    AM_REL  = 4'd6,
    AM_AINC = 4'd7,
    AM_ADEC = 4'd8
  } am_mode_e;

  typedef enum logic [1:0] {
    OK_MEM = 2'd0,
    OK_IMM = 2'd1,
    OK_REG = 2'd2
  } opnd_kind_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_MEMW = 1'b1
  } ea_state_e;

endpackage

// File: rtl/ea_calc.sv
module ea_calc
  import ea_pkg::*;
#(
  parameter int AW   = 32,
  parameter int STEP = 4
) (
  input  logic [3:0]    mode,
  input  logic [AW-1:0] disp,
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] rdata,
  output logic [AW-1:0] calc_result,
  output opnd_kind_e    calc_kind,
  output logic          calc_wb_en,
  output logic [AW-1:0] calc_wb_data,
  output logic          calc_needs_mem
);

  localparam logic [AW-1:0] STEP_V = AW'(STEP);

  function automatic logic [AW-1:0] f_offset(input logic [AW-1:0] base,
                                             input logic [AW-1:0] off);
    return base + off;
  endfunction

  function automatic logic [AW-1:0] f_step_up(input logic [AW-1:0] base);
    return base + STEP_V;
  endfunction

  function automatic logic [AW-1:0] f_step_down(input logic [AW-1:0] base);
    return base - STEP_V;
  endfunction

  always_comb begin
    calc_result    = disp;
    calc_kind      = OK_MEM;
    calc_wb_en     = 1'b0;
    calc_wb_data   = '0;
    calc_needs_mem = 1'b0;
    case (mode)
      AM_IMM: begin
        calc_result = disp;
        calc_kind   = OK_IMM;
      end
      AM_REG: begin
        calc_result = rdata;
        calc_kind   = OK_REG;
      end
      AM_ABS:  calc_result = disp;
      AM_INDR: calc_result = rdata;
      AM_INDM: calc_needs_mem = 1'b1;
      AM_IDX:  calc_result = f_offset(rdata, disp);
      AM_REL:  calc_result = f_offset(pc, disp);
      AM_AINC: begin
        calc_result  = rdata;
        calc_wb_en   = 1'b1;
        calc_wb_data = f_step_up(rdata);
      end
      AM_ADEC: begin
        calc_result  = f_step_down(rdata);
        calc_wb_en   = 1'b1;
        calc_wb_data = f_step_down(rdata);
      end
      default: calc_result = disp;
    endcase
  end

endmodule

// File: rtl/ea_ctrl.sv
module ea_ctrl
  import ea_pkg::*;
#(
  parameter int AW = 32,
  parameter int RW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [RW-1:0] reg_idx,
  input  logic [AW-1:0] disp,
  input  logic [AW-1:0] calc_result,
  input  opnd_kind_e    calc_kind,
  input  logic          calc_wb_en,
  input  logic [AW-1:0] calc_wb_data,
  input  logic          calc_needs_mem,
  input  logic          mem_ready,
  input  logic [AW-1:0] mem_rdata,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  output logic          done,
  output logic [AW-1:0] result,
  output opnd_kind_e    kind,
  output logic          rf_we,
  output logic [RW-1:0] rf_waddr,
  output logic [AW-1:0] rf_wdata,
  output logic          busy
);

  ea_state_e state;

  // named events for the checks
  logic accept_ev, fetch_ev, single_ev, mem_done_ev;

  assign busy        = (state == ST_MEMW);
  assign accept_ev   = start && !busy;
  assign fetch_ev    = accept_ev && calc_needs_mem;
  assign single_ev   = accept_ev && !calc_needs_mem;
  assign mem_done_ev = busy && mem_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      mem_req  <= 1'b0;
      mem_addr <= '0;
      done     <= 1'b0;
      result   <= '0;
      kind     <= OK_MEM;
      rf_we    <= 1'b0;
      rf_waddr <= '0;
      rf_wdata <= '0;
    end else begin
      done  <= 1'b0;
      rf_we <= 1'b0;
      if (single_ev) begin
        done     <= 1'b1;
        result   <= calc_result;
        kind     <= calc_kind;
        rf_we    <= calc_wb_en;
        rf_waddr <= reg_idx;
        rf_wdata <= calc_wb_data;
      end else if (fetch_ev) begin
        state    <= ST_MEMW;
        mem_req  <= 1'b1;
        mem_addr <= disp;
      end else if (mem_done_ev) begin
        state   <= ST_IDLE;
        mem_req <= 1'b0;
        done    <= 1'b1;
        result  <= mem_rdata;
        kind    <= OK_MEM;
      end
    end
  end

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr));

  // R10
  fetch_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ready |=> done && !mem_req && kind == OK_MEM);

  // R8
  wb_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> done);

  // R11
  busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R11
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !mem_ready |=> !done && !rf_we);

endmodule

// File: rtl/ea_unit.sv
module ea_unit
  import ea_pkg::*;
#(
  parameter int AW   = 32,
  parameter int RW   = 4,
  parameter int STEP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [3:0]    mode,
  input  logic [RW-1:0] reg_idx,
  input  logic [AW-1:0] disp,
  input  logic [AW-1:0] pc,
  output logic [RW-1:0] rf_raddr,
  input  logic [AW-1:0] rf_rdata,
  output logic          rf_we,
  output logic [RW-1:0] rf_waddr,
  output logic [AW-1:0] rf_wdata,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_ready,
  input  logic [AW-1:0] mem_rdata,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] result,
  output logic [1:0]    kind
);

  logic [AW-1:0] calc_result, calc_wb_data;
  opnd_kind_e    calc_kind, kind_q;
  logic          calc_wb_en, calc_needs_mem;

  assign rf_raddr = reg_idx;
  assign kind     = kind_q;

  ea_calc #(.AW(AW), .STEP(STEP)) calc_i (
    .mode           (mode),
    .disp           (disp),
    .pc             (pc),
    .rdata          (rf_rdata),
    .calc_result    (calc_result),
    .calc_kind      (calc_kind),
    .calc_wb_en     (calc_wb_en),
    .calc_wb_data   (calc_wb_data),
    .calc_needs_mem (calc_needs_mem)
  );

  ea_ctrl #(.AW(AW), .RW(RW)) ctrl_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .start          (start),
    .reg_idx        (reg_idx),
    .disp           (disp),
    .calc_result    (calc_result),
    .calc_kind      (calc_kind),
    .calc_wb_en     (calc_wb_en),
    .calc_wb_data   (calc_wb_data),
    .calc_needs_mem (calc_needs_mem),
    .mem_ready      (mem_ready),
    .mem_rdata      (mem_rdata),
    .mem_req        (mem_req),
    .mem_addr       (mem_addr),
    .done           (done),
    .result         (result),
    .kind           (kind_q),
    .rf_we          (rf_we),
    .rf_waddr       (rf_waddr),
    .rf_wdata       (rf_wdata),
    .busy           (busy)
  );

  // R2
  imm_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && kind_q == OK_IMM |-> !rf_we);

  // R10
  fetch_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> mem_req && !done);

endmodule

// File: tb/ea_unit_tb_top.sv
module ea_unit_tb_top;

  localparam int AW   = 32;
  localparam int RW   = 4;
  localparam int STEP = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [3:0]    mode = '0;
  logic [RW-1:0] reg_idx = '0;
  logic [AW-1:0] disp = '0;
  logic [AW-1:0] pc = '0;
  logic [RW-1:0] rf_raddr;
  logic [AW-1:0] rf_rdata;
  logic          rf_we;
  logic [RW-1:0] rf_waddr;
  logic [AW-1:0] rf_wdata;
  logic          mem_req;
  logic [AW-1:0] mem_addr;
  logic          mem_ready = 1'b0;
  logic [AW-1:0] mem_rdata = '0;
  logic          busy, done;
  logic [AW-1:0] result;
  logic [1:0]    kind;

  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;

  // register file model with a preload port
  logic [AW-1:0] regs [16];
  logic          pre_we = 1'b0;
  logic [RW-1:0] pre_idx = '0;
  logic [AW-1:0] pre_val = '0;
  assign rf_rdata = regs[rf_raddr];
  always @(posedge clk) begin
    if (pre_we) regs[pre_idx] <= pre_val;
    else if (rf_we) regs[rf_waddr] <= rf_wdata;
  end

  ea_unit #(.AW(AW), .RW(RW), .STEP(STEP)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .reg_idx(reg_idx),
    .disp(disp), .pc(pc), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ready(mem_ready),
    .mem_rdata(mem_rdata), .busy(busy), .done(done), .result(result),
    .kind(kind)
  );

  task automatic check(input string req, input logic [AW-1:0] act,
                       input logic [AW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic preload(input int idx, input logic [AW-1:0] val);
    @(negedge clk);
    pre_we = 1'b1; pre_idx = RW'(idx); pre_val = val;
    @(negedge clk);
    pre_we = 1'b0;
  endtask

  // drive one specifier; returns at the negedge after the accepting edge
  task automatic issue(input logic [3:0] m, input int idx, input logic [AW-1:0] d);
    @(negedge clk);
    start = 1'b1; mode = m; reg_idx = RW'(idx); disp = d;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 done", AW'(done), 0);
    check("R1 mem_req", AW'(mem_req), 0);
    check("R1 rf_we", AW'(rf_we), 0);
    check("R1 busy", AW'(busy), 0);
  endtask

  task automatic t_imm();
    issue(4'd0, 3, 32'hDEAD_0042);
    check("R2 done", AW'(done), 1);
    check("R2 result", result, 32'hDEAD_0042);
    check("R2 kind", AW'(kind), 1);
    check("R2 rf_we", AW'(rf_we), 0);
  endtask

  task automatic t_reg();
    preload(5, 32'h1234_5678);
    issue(4'd1, 5, 32'h0);
    check("R3 result", result, 32'h1234_5678);
    check("R3 kind", AW'(kind), 2);
  endtask

  task automatic t_abs();
    issue(4'd2, 0, 32'h0000_8000);
    check("R4 result", result, 32'h0000_8000);
    check("R4 kind", AW'(kind), 0);
  endtask

  task automatic t_indr();
    preload(2, 32'h0000_0400);
    issue(4'd3, 2, 32'h1);
    check("R5 result", result, 32'h0000_0400);
    check("R5 kind", AW'(kind), 0);
  endtask

  task automatic t_idx();
    preload(1, 32'h0000_1000);
    issue(4'd5, 1, 32'd20);
    check("R6 sum", result, 32'h0000_1014);
    preload(1, 32'hFFFF_FFF0);
    issue(4'd5, 1, 32'h20);
    check("R6 wrap", result, 32'h0000_0010);
  endtask

  task automatic t_rel();
    pc = 32'h0000_0002;
    issue(4'd6, 7, 32'd100);
    check("R7 sum", result, 32'd102);
    pc = 32'hFFFF_FFFC;
    issue(4'd6, 7, 32'h8);
    check("R7 wrap", result, 32'h0000_0004);
    check("R7 kind", AW'(kind), 0);
  endtask

  task automatic t_ainc();
    preload(4, 32'h0000_2000);
    issue(4'd7, 4, 32'h0);
    check("R8 addr", result, 32'h0000_2000);
    check("R8 we", AW'(rf_we), 1);
    check("R8 waddr", AW'(rf_waddr), 4);
    check("R8 wdata", rf_wdata, 32'h0000_2000 + STEP);
    issue(4'd7, 4, 32'h0);
    check("R8 second", result, 32'h0000_2000 + STEP);
    preload(4, 32'hFFFF_FFFE);
    issue(4'd7, 4, 32'h0);
    check("R8 wrap", rf_wdata, 32'h0000_0002);
  endtask

  task automatic t_adec();
    preload(6, 32'h0000_3000);
    issue(4'd8, 6, 32'h0);
    check("R9 addr", result, 32'h0000_3000 - STEP);
    check("R9 we", AW'(rf_we), 1);
    check("R9 wdata", rf_wdata, 32'h0000_3000 - STEP);
    issue(4'd8, 6, 32'h0);
    check("R9 second", result, 32'h0000_3000 - 2 * STEP);
  endtask

  task automatic t_indm(input int waits, input logic [AW-1:0] ptr,
                        input logic [AW-1:0] word);
    issue(4'd4, 0, ptr);
    check("R10 req", AW'(mem_req), 1);
    check("R10 addr", mem_addr, ptr);
    check("R10 no early done", AW'(done), 0);
    for (int i = 0; i < waits; i++) begin
      // R11: a start while busy must be ignored
      start = 1'b1; mode = 4'd7; reg_idx = 4'd9; disp = 32'h55;
      @(negedge clk);
      start = 1'b0;
      check("R11 no done", AW'(done), 0);
      check("R11 no write", AW'(rf_we), 0);
      check("R10 held addr", mem_addr, ptr);
    end
    mem_ready = 1'b1; mem_rdata = word;
    @(negedge clk);
    mem_ready = 1'b0;
    check("R10 done", AW'(done), 1);
    check("R10 result", result, word);
    check("R10 kind", AW'(kind), 0);
    check("R10 req drop", AW'(mem_req), 0);
    @(negedge clk);
    check("R11 no late done", AW'(done), 0);
  endtask

  task automatic t_reserved();
    issue(4'd12, 2, 32'h0000_0ABC);
    check("R12 result", result, 32'h0000_0ABC);
    check("R12 kind", AW'(kind), 0);
    check("R12 we", AW'(rf_we), 0);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
  end

  initial begin
    for (int i = 0; i < 16; i++) regs[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_imm();
    t_reg();
    t_abs();
    t_indr();
    t_idx();
    t_rel();
    t_ainc();
    t_adec();
    t_indm(0, 32'h0000_0100, 32'hCAFE_0000);
    t_indm(3, 32'h0000_0200, 32'h0BAD_F00D);
    t_reserved();
    summary();
  end

endmodule